// File: doc/BRIEF.md
# Reloadable 16-bit Timer with Clock Output

This block is a 16-bit up-counter paired with a 16-bit reload/capture register and one control register, all reached through a byte-wide register port. It can count internal ticks or falling edges on an external count pin. On overflow it either reloads from the reload register or wraps to zero. A falling edge on an external trigger pin can capture the running count or force a reload.

In clock-output mode the counter runs at half the tick rate and reloads on every overflow. An output flop flips on each overflow, which gives a square wave with 50% duty cycle. Two baud-select bits stand in for serial-port clock routing. Either one forces auto-reload, stops overflow flag updates and blocks trigger-driven capture or reload. The overflow and trigger flags are brought out as interrupt lines, and only a software write clears them.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads 0x00, `clk_out_o` is 0 and both interrupt outputs are 0.
- R2: Register addresses are 0 control, 1 mode, 2/3 counter low/high, 4/5 reload low/high. Control bits from 7 to 0 are: overflow flag, trigger flag, receive-baud select, transmit-baud select, trigger enable, run, count-source select (1 = external pin), capture select. In the mode register only bit 1 (clock-output enable) is stored; all other mode bits read 0.
- R3: With run=1 and count-source=0 (clock output off) the counter adds 1 on each cycle with `tick_i` high. With run=0 the counter holds its value.
- R4: An overflow from 0xFFFF with capture select 0 loads the reload register into the counter and sets the overflow flag. `irq_ovf_o` follows the flag, and only a software write to the control register clears it.
- R5: An overflow with capture select 1 (no baud bit set, clock output off) wraps the counter to 0x0000 and sets the overflow flag.
- R6: With trigger enable 1 and capture select 1, a falling edge on `ext_trig_i` copies the counter into the reload register and sets the trigger flag (`irq_ext_o`).
- R7: With trigger enable 1 and capture select 0, a falling edge on `ext_trig_i` loads the reload register into the counter and sets the trigger flag.
- R8: With trigger enable 0, a falling edge on `ext_trig_i` changes neither the counter, the reload register nor the flags.
- R9: While either baud-select bit is 1, an overflow reloads the counter whatever the capture select, and the overflow flag stays clear. A trigger edge sets only the trigger flag and causes no capture or reload.
- R10: With count-source 1 the counter adds 1 per falling edge on `ext_cnt_i` and ignores `tick_i`.
- R11: With clock-output enable 1 and count-source 0, the counter advances on every second tick and reloads on each overflow. `clk_out_o` flips on each overflow, so with `tick_i` held high it flips every 2*(65536-R) cycles, where R is the reload value. Such overflows leave the overflow flag clear.
- R12: `clk_out_o` holds its value while run is 0 or clock-output enable is 0.
- R13: A software write to a counter byte in the same cycle as an overflow reload wins for that byte. The other byte takes the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count enable, one pulse per count |
| ext_trig_i | input | 1 | Asynchronous trigger pin, falling edge active |
| ext_cnt_i | input | 1 | Asynchronous external count pin, falling edge active |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | BW | Write data |
| rdata_o | output | BW | Read data, combinational from `addr_i` |
| irq_ovf_o | output | 1 | Overflow flag |
| irq_ext_o | output | 1 | Trigger flag |
| clk_out_o | output | 1 | Generated clock output |

## Verification
The assertions assume that the two pins change slowly enough for the synchronizers to see every level: each low or high phase lasts at least two clock cycles. They also assume that a software write to the control register is the only way, apart from the overflow and trigger events, for a flag to change. The stimulus holds each pin level for four or more cycles. It drives the register port and `tick_i` only at falling clock edges, and gates counting through `tick_i`, so that every increment and overflow lands on a known edge.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_baud;
    logic tx_baud;
    logic ext_en;
    logic run;
    logic src_ext;
    logic cap_sel;
  } rt_ctrl_t;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_MODE   = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_CNT_HI = 3'd3,
    RA_RLD_LO = 3'd4,
    RA_RLD_HI = 3'd5
  } rt_addr_e;

  localparam int OE_BIT = 1;
endpackage

// File: rtl/rt_fall_sync.sv
module rt_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/rt_core.sv
module rt_core #(
  parameter int BW = 8,
  parameter int NB = 2,
  localparam int CW = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          src_ext_i,
  input  logic          cap_sel_i,
  input  logic          baud_i,
  input  logic          ext_en_i,
  input  logic          oe_i,
  input  logic          tick_i,
  input  logic          cnt_fall_i,
  input  logic          trig_fall_i,
  input  logic [NB-1:0] wr_cnt_i,
  input  logic [NB-1:0] wr_rld_i,
  input  logic [BW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output logic          clkmode_o,
  output logic          ovf_o,
  output logic          ovf_reload_o,
  output logic          trig_evt_o,
  output logic          trig_rld_o,
  output logic          clk_out_o
);
  localparam logic [CW-1:0] LAST = '1;

  function automatic logic [CW-1:0] step_up(input logic [CW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic at_last(input logic [CW-1:0] v);
    return v == LAST;
  endfunction

  logic [CW-1:0] cnt_q, rld_q, cnt_base;
  logic          half_q, clk_q;
  logic          clkmode, inc, ovf, ovf_reload, trig_evt, trig_cap, trig_rld;

  assign clkmode    = oe_i && !src_ext_i;
  assign inc        = run_i && (src_ext_i ? cnt_fall_i
                                          : (tick_i && (!clkmode || half_q)));
  assign ovf        = inc && at_last(cnt_q);
  assign ovf_reload = ovf && (baud_i || clkmode || !cap_sel_i);
  assign trig_evt   = ext_en_i && trig_fall_i;
  assign trig_cap   = trig_evt && cap_sel_i && !baud_i;
  assign trig_rld   = trig_evt && !cap_sel_i && !baud_i;

  always_comb begin
    if (ovf_reload || trig_rld) cnt_base = rld_q;
    else if (inc)               cnt_base = step_up(cnt_q);
    else                        cnt_base = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  half_q <= 1'b0;
    else if (!run_i)             half_q <= 1'b0;
    else if (tick_i && clkmode)  half_q <= ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clk_q <= 1'b0;
    else if (ovf && clkmode)   clk_q <= ~clk_q;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[b*BW +: BW] <= '0;
        rld_q[b*BW +: BW] <= '0;
      end else begin
        cnt_q[b*BW +: BW] <= wr_cnt_i[b] ? wdata_i : cnt_base[b*BW +: BW];
        if (wr_rld_i[b])   rld_q[b*BW +: BW] <= wdata_i;
        else if (trig_cap) rld_q[b*BW +: BW] <= cnt_q[b*BW +: BW];
      end
    end
  end

  assign cnt_o        = cnt_q;
  assign rld_o        = rld_q;
  assign clkmode_o    = clkmode;
  assign ovf_o        = ovf;
  assign ovf_reload_o = ovf_reload;
  assign trig_evt_o   = trig_evt;
  assign trig_rld_o   = trig_rld;
  assign clk_out_o    = clk_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int BW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ext_trig_i,
  input  logic          ext_cnt_i,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          irq_ovf_o,
  output logic          irq_ext_o,
  output logic          clk_out_o
);
  localparam int NB = 2;
  localparam int CW = BW * NB;
  localparam int NPIN = 2;

  rt_ctrl_t      ctrl_q;
  logic          oe_q;
  logic [CW-1:0] cnt_w, rld_w;
  logic [NB-1:0] wr_cnt, wr_rld;
  logic          wr_ctrl, wr_mode, wr_cnt_any, baud;
  logic          clkmode_w, ovf_w, ovf_reload_w, trig_evt_w, trig_rld_w, set_tf;
  logic [NPIN-1:0] pin_raw, pin_fall;

  assign pin_raw = {ext_cnt_i, ext_trig_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    rt_fall_sync #(.STAGES(SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw[p]),
      .fall_o(pin_fall[p])
    );
  end

  assign wr_ctrl = wr_en_i && (addr_i == RA_CTRL);
  assign wr_mode = wr_en_i && (addr_i == RA_MODE);
  for (genvar b = 0; b < NB; b++) begin : g_wdec
    assign wr_cnt[b] = wr_en_i && (addr_i == 3'(RA_CNT_LO + b));
    assign wr_rld[b] = wr_en_i && (addr_i == 3'(RA_RLD_LO + b));
  end
  assign wr_cnt_any = |wr_cnt;
  assign baud       = ctrl_q.rx_baud || ctrl_q.tx_baud;

  rt_core #(.BW(BW), .NB(NB)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ctrl_q.run),
    .src_ext_i   (ctrl_q.src_ext),
    .cap_sel_i   (ctrl_q.cap_sel),
    .baud_i      (baud),
    .ext_en_i    (ctrl_q.ext_en),
    .oe_i        (oe_q),
    .tick_i      (tick_i),
    .cnt_fall_i  (pin_fall[1]),
    .trig_fall_i (pin_fall[0]),
    .wr_cnt_i    (wr_cnt),
    .wr_rld_i    (wr_rld),
    .wdata_i     (wdata_i),
    .cnt_o       (cnt_w),
    .rld_o       (rld_w),
    .clkmode_o   (clkmode_w),
    .ovf_o       (ovf_w),
    .ovf_reload_o(ovf_reload_w),
    .trig_evt_o  (trig_evt_w),
    .trig_rld_o  (trig_rld_w),
    .clk_out_o   (clk_out_o)
  );

  assign set_tf = ovf_w && !baud && !clkmode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= rt_ctrl_t'(wdata_i[7:0]);
      if (set_tf)     ctrl_q.ovf_flag <= 1'b1;
      if (trig_evt_w) ctrl_q.ext_flag <= 1'b1;
      if (wr_mode) oe_q <= wdata_i[OE_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL:   rdata_o = BW'(ctrl_q);
      RA_MODE:   rdata_o[OE_BIT] = oe_q;
      RA_CNT_LO: rdata_o = cnt_w[BW-1:0];
      RA_CNT_HI: rdata_o = cnt_w[CW-1:BW];
      RA_RLD_LO: rdata_o = rld_w[BW-1:0];
      RA_RLD_HI: rdata_o = rld_w[CW-1:BW];
      default:   rdata_o = '0;
    endcase
  end

  assign irq_ovf_o = ctrl_q.ovf_flag;
  assign irq_ext_o = ctrl_q.ext_flag;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ovf,
  input logic          ovf_reload,
  input logic          trig_evt,
  input logic          trig_rld,
  input logic          wr_cnt_any,
  input logic          wr_ctrl,
  input logic          run,
  input logic          baud,
  input logic          tf,
  input logic          exf,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rld,
  input logic          clk_out
);
  // R4
  reload_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_reload && !wr_cnt_any) |=> (cnt == $past(rld)));

  // R3
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt_any && !trig_rld) |=> $stable(cnt));

  // R6
  trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> exf);

  // R9
  baud_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && baud && !tf && !wr_ctrl) |=> !tf);

  // R11
  clk_out_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(ovf));

  // R4
  tf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf) |-> ($past(ovf) || $past(wr_ctrl)));
endmodule

bind reload_timer rt_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ovf       (ovf_w),
  .ovf_reload(ovf_reload_w),
  .trig_evt  (trig_evt_w),
  .trig_rld  (trig_rld_w),
  .wr_cnt_any(wr_cnt_any),
  .wr_ctrl   (wr_ctrl),
  .run       (ctrl_q.run),
  .baud      (baud),
  .tf        (ctrl_q.ovf_flag),
  .exf       (ctrl_q.ext_flag),
  .cnt       (cnt_w),
  .rld       (rld_w),
  .clk_out   (clk_out_o)
);

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // {reload value, expected cycles between clk_out flips}
  localparam logic [31:0] VEC [NV] = '{
    {16'hFFFF, 16'd2}, {16'hFFFE, 16'd4}, {16'hFFF0, 16'd32}, {16'hFF00, 16'd512}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, trig = 1'b1, ecnt = 1'b1, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq_ovf, irq_ext, clk_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_trig_i(trig), .ext_cnt_i(ecnt),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_ovf_o(irq_ovf), .irq_ext_o(irq_ext), .clk_out_o(clk_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rreg(a, lo); rreg(3'(a + 1), hi); v = {hi, lo};
  endtask

  task automatic w16(input logic [2:0] a, input logic [15:0] v);
    wreg(a, v[7:0]); wreg(3'(a + 1), v[15:8]);
  endtask

  task automatic tick_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic trig_fall();
    @(negedge clk); trig = 1'b0;
    repeat (5) @(negedge clk);
    trig = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), b); chk("R1 reg", b, 8'h00);
    end
    chk("R1 outs", {irq_ovf, irq_ext, clk_out}, 3'b000);

    // R2 mode register keeps only bit 1
    wreg(3'd1, 8'hFF); rreg(3'd1, b); chk("R2 mode", b, 8'h02);
    wreg(3'd1, 8'h00);

    // Table walk: clock-output periods, R11
    for (int i = 0; i < NV; i++) begin
      int n;
      logic p;
      tick = 1'b0;
      wreg(3'd0, 8'h00); wreg(3'd1, 8'h02);
      w16(3'd4, VEC[i][31:16]); w16(3'd2, VEC[i][31:16]);
      wreg(3'd0, 8'h04);
      @(negedge clk); tick = 1'b1;
      p = clk_out; n = 0;
      while (clk_out == p && n < 5000) begin @(negedge clk); n++; end
      p = clk_out; n = 0;
      while (clk_out == p && n < 5000) begin @(negedge clk); n++; end
      chk("R11 half period", n, {16'h0, VEC[i][15:0]});
      tick = 1'b0;
      rreg(3'd0, b); chk("R11 no ovf flag", b, 8'h04);
    end

    // R12 run=0 with output enabled: no flips
    wreg(3'd0, 8'h00); w16(3'd2, 16'hFFFF); w16(3'd4, 16'hFFFF);
    b = {7'd0, clk_out};
    @(negedge clk); tick = 1'b1; repeat (30) @(negedge clk); tick = 1'b0;
    chk("R12 run off", clk_out, b[0]);
    // R12 output disabled, running: overflows but no flips
    wreg(3'd1, 8'h00); w16(3'd2, 16'hFFF0); wreg(3'd0, 8'h04);
    @(negedge clk); tick = 1'b1; repeat (40) @(negedge clk); tick = 1'b0;
    chk("R12 oe off", clk_out, b[0]);
    rreg(3'd0, b); chk("R4 flag via oe off", b, 8'h84);

    // R3 and R4: timer auto-reload
    wreg(3'd0, 8'h00); w16(3'd4, 16'h1234); w16(3'd2, 16'hFFFE);
    wreg(3'd0, 8'h04);
    tick_pulses(1); rd16(3'd2, v); chk("R3 count up", v, 16'hFFFF);
    tick_pulses(2); rd16(3'd2, v); chk("R4 reload", v, 16'h1235);
    rreg(3'd0, b); chk("R4 flag", b, 8'h84);
    chk("R4 irq", irq_ovf, 1'b1);
    wreg(3'd0, 8'h00); rreg(3'd0, b); chk("R4 sw clear", b, 8'h00);

    // R3 run=0 freeze
    @(negedge clk); tick = 1'b1; repeat (10) @(negedge clk); tick = 1'b0;
    rd16(3'd2, v); chk("R3 frozen", v, 16'h1235);

    // R5 capture mode wrap
    w16(3'd2, 16'hFFFF); wreg(3'd0, 8'h05);
    tick_pulses(1); rd16(3'd2, v); chk("R5 wrap", v, 16'h0000);
    rreg(3'd0, b); chk("R5 flag", b, 8'h85);

    // R6 capture on trigger
    wreg(3'd0, 8'h09); w16(3'd2, 16'hABCD); w16(3'd4, 16'h0000);
    trig_fall();
    rd16(3'd4, v); chk("R6 capture", v, 16'hABCD);
    rreg(3'd0, b); chk("R6 flag", b, 8'h49);
    chk("R6 irq", irq_ext, 1'b1);

    // R7 reload on trigger
    wreg(3'd0, 8'h08); w16(3'd4, 16'h5555); w16(3'd2, 16'h0001);
    trig_fall();
    rd16(3'd2, v); chk("R7 reload", v, 16'h5555);
    rreg(3'd0, b); chk("R7 flag", b, 8'h48);

    // R8 trigger disabled
    wreg(3'd0, 8'h01); w16(3'd4, 16'h4000); w16(3'd2, 16'h0123);
    trig_fall();
    rd16(3'd4, v); chk("R8 rld kept", v, 16'h4000);
    rd16(3'd2, v); chk("R8 cnt kept", v, 16'h0123);
    rreg(3'd0, b); chk("R8 no flag", b, 8'h01);

    // R9 baud select: forced reload, no flag
    wreg(3'd0, 8'h00); w16(3'd2, 16'hFFFF); wreg(3'd0, 8'h25);
    tick_pulses(1); rd16(3'd2, v); chk("R9 forced reload", v, 16'h4000);
    rreg(3'd0, b); chk("R9 no ovf flag", b, 8'h25);
    // R9 trigger with baud: flag only
    wreg(3'd0, 8'h19); w16(3'd2, 16'h0777);
    trig_fall();
    rd16(3'd4, v); chk("R9 no capture", v, 16'h4000);
    rreg(3'd0, b); chk("R9 ext flag", b, 8'h59);

    // R10 external count source
    wreg(3'd0, 8'h00); w16(3'd2, 16'h0010); wreg(3'd0, 8'h06);
    @(negedge clk); tick = 1'b1;
    for (int k = 0; k < 3; k++) begin
      ecnt = 1'b0; repeat (4) @(negedge clk);
      ecnt = 1'b1; repeat (4) @(negedge clk);
    end
    tick = 1'b0;
    repeat (4) @(negedge clk);
    wreg(3'd0, 8'h00);
    rd16(3'd2, v); chk("R10 edge count", v, 16'h0013);

    // R13 software write beats overflow reload
    w16(3'd4, 16'h1111); w16(3'd2, 16'hFFFF); wreg(3'd0, 8'h04);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 3'd2; wdata = 8'h77;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rd16(3'd2, v); chk("R13 write wins", v, 16'h1177);
    rreg(3'd0, b); chk("R13 flag", b, 8'h84);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule